// File: doc/BRIEF.md
# Locked Test-and-Set Semaphore Unit

This block puts four processors on one shared path to a small store of one-bit semaphore words. A semaphore at 1 marks a protected resource as taken: some processor is inside its critical section. A semaphore at 0 marks it free. Each processor can ask for a plain read, a plain write, or an atomic test-and-set. A test-and-set returns the value the semaphore held and leaves a 1 behind.

An arbiter hands the shared path to one requester at a time. When several requesters compete, the lowest index wins. A test-and-set takes a read cycle and then a write cycle. The requester raises its lock line for the whole operation. While the owner's lock is high, the arbiter keeps its grant on that owner. This is how the read and the write stay together: no other processor can change the semaphore between them. A processor releases a semaphore by writing 0 to it with an ordinary write once its critical section is finished.

Top module: `sem_lock_unit`

## Requirements
- R1: A synchronous active-high reset clears every semaphore to 0 and drives all grant, done and read-data outputs low; after reset a read of any address returns 0.
- R2: In a cycle with no grant, the requesting port with the lowest index is chosen, and its grant is high from the next cycle on.
- R3: At most one grant bit is high in any cycle.
- R4: The op field of port i occupies op bits [2i+1:2i]; code 00 reads, 01 writes, 10 is test-and-set, 11 reads. A granted read with req high raises done in that same cycle, and rdata carries the addressed semaphore.
- R5: A granted write with req high raises done in that cycle and stores wdata; later reads see the new value, so writing 0 frees a semaphore.
- R6: A granted test-and-set uses exactly two cycles; done is high only in the second, rdata then carries the value held before the operation, and the semaphore reads 1 afterwards.
- R7: While the owner's lock is high, its grant stays and no other port is granted, with or without a pending request from the owner.
- R8: After a done cycle with the owner's lock low, the grant is low in the next cycle; the same applies to a granted cycle with req and lock both low.
- R9: When several ports test-and-set the same free semaphore, exactly one of them receives 0.
- R10: A port that is not granted, or is granted but not in a done cycle, sees done and rdata low. The address of port i is addr bits [4i+3:4i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Request, one bit per port |
| lock | input | 4 | Lock line, one bit per port |
| op | input | 8 | Operation code, two bits per port |
| addr | input | 16 | Semaphore address, four bits per port |
| wdata | input | 4 | Write value, one bit per port |
| gnt | output | 4 | Grant, one-hot or zero |
| done | output | 4 | Completion strobe per port |
| rdata | output | 4 | Prior semaphore value, valid with done |

## Verification
A grant appears one cycle after the idle cycle in which a request is seen. A read or write finishes in the first granted cycle. A test-and-set finishes one cycle later, and the grant drops in the cycle after done unless the lock is held. The bench steps a behavioural model on the same rising edge that updates the design. It compares grant, done and read data at every falling edge, before any input changes, so each result is checked in the exact cycle it is due. Contention scenarios also record the order in which the ports complete and the values they receive. These are checked against the priority rule and the single-winner rule.

// File: rtl/sem_lock_unit.sv
module sem_lock_unit #(
  parameter int NPORT = 4,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   req,
  input  logic [NPORT-1:0]   lock,
  input  logic [2*NPORT-1:0] op,
  input  logic [AW*NPORT-1:0] addr,
  input  logic [NPORT-1:0]   wdata,
  output logic [NPORT-1:0]   gnt,
  output logic [NPORT-1:0]   done,
  output logic [NPORT-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1;

  logic [DEPTH-1:0] sem;
  logic             busy, second;
  logic [IW-1:0]    owner;
  logic             held_val;
  logic [AW-1:0]    held_addr;
  logic [IW-1:0]    winner;
  logic             any_req;

  wire [1:0]    cur_op   = op[2*owner +: 2];
  wire [AW-1:0] cur_addr = addr[AW*owner +: AW];
  wire          cur_req  = req[owner];
  wire          cur_lock = lock[owner];
  wire          is_tas   = cur_op == 2'b10;
  wire          is_wr    = cur_op == 2'b01;
  wire          finish   = busy & (second | (cur_req & ~is_tas));
  wire          out_val  = second ? held_val : sem[cur_addr];

  always_comb begin
    winner  = '0;
    any_req = 1'b0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (req[i]) begin
        winner  = IW'(i);
        any_req = 1'b1;
      end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign gnt[g]   = busy && (owner == IW'(g));
    assign done[g]  = gnt[g] & finish;
    assign rdata[g] = done[g] & out_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sem       <= '0;
      busy      <= 1'b0;
      second    <= 1'b0;
      owner     <= '0;
      held_val  <= 1'b0;
      held_addr <= '0;
    end else if (!busy) begin
      if (any_req) begin
        busy   <= 1'b1;
        owner  <= winner;
        second <= 1'b0;
      end
    end else if (second) begin
      sem[held_addr] <= 1'b1;
      second         <= 1'b0;
      if (!cur_lock) busy <= 1'b0;
    end else if (cur_req && is_tas) begin
      held_val  <= sem[cur_addr];
      held_addr <= cur_addr;
      second    <= 1'b1;
    end else begin
      if (cur_req && is_wr) sem[cur_addr] <= wdata[owner];
      if (!cur_lock) busy <= 1'b0;
    end
  end

  assert_single_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_new_grant_priority_R2: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && $past(gnt) == '0) |->
      ((gnt & $past(req)) == gnt) && (($past(req) & (gnt - 1'b1)) == '0));

  assert_lock_keeps_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (gnt & lock) != '0 |=> gnt == $past(gnt));

  assert_unlocked_release_R8: assert property (@(posedge clk) disable iff (rst)
    (done & ~lock) != '0 |=> gnt == '0);

  assert_tas_leaves_one_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && second) |=> sem[$past(held_addr)]);
endmodule

// File: tb/sem_lock_unit_bench.sv
module sem_lock_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req = '0, lock = '0, wdata = '0;
  logic [7:0]  op = '0;
  logic [15:0] addr = '0;
  logic [3:0]  gnt, done, rdata;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  sem_lock_unit u_sem_lock_unit (
    .clk(clk), .rst(rst), .req(req), .lock(lock), .op(op),
    .addr(addr), .wdata(wdata), .gnt(gnt), .done(done), .rdata(rdata)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int m_own = -1;
  bit m_ph = 0;
  bit m_sem [16];
  bit m_old = 0;
  int m_ta = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_own = -1; m_ph = 0;
      foreach (m_sem[k]) m_sem[k] = 0;
    end else if (m_own < 0) begin
      for (int i = 0; i < 4; i++)
        if (req[i]) begin m_own = i; m_ph = 0; break; end
    end else begin
      int o;
      int a;
      int c;
      o = m_own;
      a = addr[4*o +: 4];
      c = op[2*o +: 2];
      if (m_ph) begin
        m_sem[m_ta] = 1; m_ph = 0;
        if (!lock[o]) m_own = -1;
      end else if (req[o] && c == 2) begin
        m_old = m_sem[a]; m_ta = a; m_ph = 1;
      end else begin
        if (req[o] && c == 1) m_sem[a] = wdata[o];
        if (!lock[o]) m_own = -1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [3:0] eg, ed, er;
      eg = '0; ed = '0; er = '0;
      if (m_own >= 0) begin
        eg[m_own] = 1'b1;
        if (m_ph || (req[m_own] && op[2*m_own +: 2] != 2'b10)) begin
          ed[m_own] = 1'b1;
          er[m_own] = m_ph ? m_old : m_sem[addr[4*m_own +: 4]];
        end
      end
      check(gnt === eg, "R2 R7 R8 grant", gnt, eg);
      check(done === ed, "R4 R5 R6 done", done, ed);
      check(rdata === er, "R4 R6 R10 rdata", rdata, er);
      check($countones(gnt) <= 1, "R3 one grant", $countones(gnt), 1);
    end
  end

  int seq = 0;

  task automatic run_op(input int p, input logic [1:0] o, input int a,
                        input logic wd, input int hold,
                        output logic rv, output int order);
    @(posedge clk); #2;
    req[p] = 1'b1;
    op[2*p +: 2] = o;
    addr[4*p +: 4] = 4'(a);
    wdata[p] = wd;
    lock[p] = (o == 2'b10) || (hold > 0);
    do @(negedge clk); while (!done[p]);
    rv = rdata[p];
    order = seq++;
    @(posedge clk); #2;
    req[p] = 1'b0;
    if (hold > 0) begin
      repeat (hold) @(posedge clk);
      #2;
    end
    lock[p] = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic v0, v1, v2, v3;
    int o0, o1, o2, o3, zeros;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gnt === 4'b0 && done === 4'b0 && rdata === 4'b0, "R1 reset outputs",
          {gnt, done, rdata}, 0);
    @(posedge clk); #2; rst = 1'b0;

    // R1: all semaphores read back 0
    for (int a = 0; a < 16; a++) begin
      run_op(a % 4, 2'b00, a, 1'b0, 0, v0, o0);
      check(v0 === 1'b0, "R1 cleared semaphore", v0, 0);
    end

    // R5 write then R4 read back, R4 op 11 reads
    run_op(1, 2'b01, 3, 1'b1, 0, v0, o0);
    run_op(0, 2'b00, 3, 1'b0, 0, v0, o0);
    check(v0 === 1'b1, "R5 written value read", v0, 1);
    run_op(2, 2'b11, 3, 1'b0, 0, v0, o0);
    check(v0 === 1'b1, "R4 code 11 reads", v0, 1);
    run_op(3, 2'b01, 3, 1'b0, 0, v0, o0);
    run_op(2, 2'b00, 3, 1'b0, 0, v0, o0);
    check(v0 === 1'b0, "R5 write 0 frees", v0, 0);

    // R2 priority among simultaneous readers
    fork
      run_op(3, 2'b00, 1, 1'b0, 0, v3, o3);
      run_op(1, 2'b00, 1, 1'b0, 0, v1, o1);
      run_op(2, 2'b00, 1, 1'b0, 0, v2, o2);
    join
    check(o1 < o2 && o2 < o3, "R2 lowest index first", o1 * 100 + o2 * 10 + o3, 0);

    // R6 single test-and-set on a free word, then again on a taken word
    run_op(2, 2'b10, 7, 1'b0, 0, v0, o0);
    check(v0 === 1'b0, "R6 old value free", v0, 0);
    run_op(0, 2'b00, 7, 1'b0, 0, v0, o0);
    check(v0 === 1'b1, "R6 semaphore now set", v0, 1);
    run_op(1, 2'b10, 7, 1'b0, 0, v0, o0);
    check(v0 === 1'b1, "R6 old value taken", v0, 1);

    // R9 all four contend on a free word
    fork
      run_op(0, 2'b10, 9, 1'b0, 0, v0, o0);
      run_op(1, 2'b10, 9, 1'b0, 0, v1, o1);
      run_op(2, 2'b10, 9, 1'b0, 0, v2, o2);
      run_op(3, 2'b10, 9, 1'b0, 0, v3, o3);
    join
    zeros = (v0 == 0) + (v1 == 0) + (v2 == 0) + (v3 == 0);
    check(zeros == 1, "R9 single winner", zeros, 1);
    check(v0 === 1'b0, "R9 priority winner port 0", v0, 0);

    // R5 release and a two-port contention on the same word
    run_op(0, 2'b01, 9, 1'b0, 0, v0, o0);
    fork
      run_op(3, 2'b10, 9, 1'b0, 0, v3, o3);
      run_op(1, 2'b10, 9, 1'b0, 0, v1, o1);
    join
    check((v1 == 0) + (v3 == 0) == 1 && v1 === 1'b0, "R9 pair single winner",
          {v1, v3}, 2'b01);

    // R7 lock held after done blocks a higher-priority request
    fork
      run_op(3, 2'b10, 12, 1'b0, 6, v3, o3);
      begin
        repeat (2) @(posedge clk);
        run_op(0, 2'b00, 12, 1'b0, 0, v0, o0);
      end
    join
    check(o3 < o0 && v3 === 1'b0 && v0 === 1'b1, "R7 lock holds bus",
          {v3, v0}, 2'b01);

    // R8 idle grant with neither req nor lock releases (covered by model);
    // R10 idle outputs quiet
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(gnt === 4'b0 && done === 4'b0 && rdata === 4'b0, "R8 R10 idle quiet",
          {gnt, done, rdata}, 0);
    summary();
  end
endmodule